// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider Tree

This block produces the count enables for a bank of five general-purpose timers that all run from one bus clock. Two programmable 8-bit prescalers each serve one group of timers. The first group is timers 0 and 1, and the second group is timers 2, 3 and 4. Every timer has its own 4-bit select code. That code either picks a power-of-two division of its group's prescaled enable or picks the external timer clock that its group shares. The timer counters downstream advance only in cycles where their tick is high.

Two configuration words are written and read through a simple one-cycle register port. Word 0 holds both prescaler values. Word 1 holds the five select codes. A static variant input sets how the select codes are decoded. All outputs are single-cycle enables in the bus clock domain, so switching a timer's source cannot produce a runt clock.

Top module: `tmr_tick_tree`

## Requirements
- R1: While reset is high and in the cycle after it, `tick_o` is all zero. After reset, both configuration words read back as zero.
- R2: A write stores word 0 bits 15:0 or word 1 bits 19:0. A read returns the stored bits, and the unused upper bits (31:16 of word 0, 31:20 of word 1) read as zero.
- R3: The prescaler for timers 0 and 1 takes its value P from word 0 bits 7:0. The prescaler for timers 2 to 4 takes P from word 0 bits 15:8. Each prescaler gives one enable every P+1 bus cycles, so P=0 gives an enable every cycle.
- R4: With `variant_b`=0, timer i's code sits at word 1 bits 4i+3:4i. Codes 0, 1, 2 and 3 divide the prescaled enable by 2, 4, 8 and 16. Code 4 selects the group's external clock.
- R5: With `variant_b`=0, codes 5 to 15 behave as divide-by-16.
- R6: With `variant_b`=1, codes 0 to 4 divide by 1, 2, 4, 8 and 16. Codes 5 to 15 select the group's external clock.
- R7: Take a timer in divide mode with ratio N and prescaler value P. Count cycles from the clock edge that captures the last configuration write as cycle 0. The timer's tick is high in cycle k·N·(P+1) for every k≥1 and in no other cycle.
- R8: Any configuration write restarts both prescalers and all five dividers. No tick is high in the cycle that follows the write edge.
- R9: External clock 0 serves timers 0 and 1, and external clock 1 serves timers 2 to 4. When an external clock rises, each timer of its group that is in external mode gives exactly one tick, three bus clock edges after the rise. A held level or a falling edge gives no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_b | input | 1 | Static select-code decoding variant (0 = A, 1 = B) |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Word written: 0 = prescalers, 1 = select codes |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 1 | Word read back |
| cfg_rd_data | output | 32 | Read data of the selected word |
| ext_clk_in | input | 2 | External timer clocks, one per group (asynchronous) |
| tick_o | output | 5 | Single-cycle tick enable per timer |

## Verification
The hardest case to reach is the slowest divided tick: a prescaler value of 255 combined with divide-by-16, which first fires 4096 cycles after a write. A directed run holds that configuration over two full periods, while another timer in the same run ticks every cycle, so phase counting is checked at both ends of the range. External-source ticks need an edge that passes through the synchronizer and the mux at the same time as divided timers run in the other group. The bench does this with a large prescale, so the divided timers stay silent during the short window in which each external edge is checked.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    localparam int unsigned TMR_COUNT  = 5;
    localparam int unsigned GRP_COUNT  = 2;
    localparam int unsigned GRP0_TMRS  = 2;
    localparam int unsigned PRE_WIDTH  = 8;
    localparam int unsigned CODE_WIDTH = 4;
    localparam int unsigned MAX_LOG2   = 4;
    localparam int unsigned LOG_WIDTH  = $clog2(MAX_LOG2 + 1);
    localparam int unsigned BUS_WIDTH  = 32;

    typedef enum logic {
        DEC_VAR_A = 1'b0,
        DEC_VAR_B = 1'b1
    } dec_variant_e;

    typedef struct packed {
        logic                 use_ext;
        logic [LOG_WIDTH-1:0] log2div;
    } src_cfg_t;

    function automatic int unsigned group_of(input int unsigned tmr, input int unsigned grp0_tmrs);
        return (tmr < grp0_tmrs) ? 0 : 1;
    endfunction

    function automatic src_cfg_t decode_code(input logic [CODE_WIDTH-1:0] code, input dec_variant_e var_sel);
        src_cfg_t res;
        res.use_ext = 1'b0;
        res.log2div = LOG_WIDTH'(MAX_LOG2);
        if (var_sel == DEC_VAR_A) begin
            if (int'(code) < 4) begin
                res.log2div = LOG_WIDTH'(code) + LOG_WIDTH'(1);
            end else if (int'(code) == 4) begin
                res.use_ext = 1'b1;
            end
        end else begin
            if (int'(code) <= 4) begin
                res.log2div = LOG_WIDTH'(code);
            end else begin
                res.use_ext = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import tmr_tick_pkg::*;
#(
    parameter int unsigned DATA_W  = BUS_WIDTH,
    parameter int unsigned NUM_GRP = GRP_COUNT,
    parameter int unsigned NUM_TMR = TMR_COUNT,
    parameter int unsigned PRE_W   = PRE_WIDTH
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic                                 wr_sel,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 rd_sel,
    output logic [DATA_W-1:0]                    rd_data,
    output logic [NUM_GRP-1:0][PRE_W-1:0]        pre_val,
    output logic [NUM_TMR-1:0][CODE_WIDTH-1:0]   sel_code,
    output logic                                 restart
);
    localparam int unsigned W0 = NUM_GRP * PRE_W;
    localparam int unsigned W1 = NUM_TMR * CODE_WIDTH;

    logic [W0-1:0] word0_q;
    logic [W1-1:0] word1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word0_q <= '0;
            word1_q <= '0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                word0_q <= wr_data[W0-1:0];
            end else begin
                word1_q <= wr_data[W1-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            rd_data[W0-1:0] = word0_q;
        end else begin
            rd_data[W1-1:0] = word1_q;
        end
    end

    assign pre_val  = word0_q;
    assign sel_code = word1_q;
    assign restart  = rst | wr_en;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_val,
    output logic             pre_en
);
    logic [PRE_W-1:0] cnt_q;

    assign pre_en = (cnt_q >= pre_val);

    always_ff @(posedge clk) begin
        if (restart || pre_en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic rise
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ext_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/tmr_chan_div.sv
module tmr_chan_div
    import tmr_tick_pkg::*;
(
    input  logic                  clk,
    input  logic                  restart,
    input  dec_variant_e          var_sel,
    input  logic [CODE_WIDTH-1:0] code,
    input  logic                  pre_en,
    input  logic                  ext_rise,
    output logic                  tick,
    output logic                  is_ext
);
    src_cfg_t              src;
    logic [MAX_LOG2-1:0]   div_cnt_q;
    logic [MAX_LOG2-1:0]   mask;
    logic                  div_hit;
    logic                  tick_q;

    assign src     = decode_code(code, var_sel);
    assign mask    = ~({MAX_LOG2{1'b1}} << src.log2div);
    assign div_hit = pre_en && ((div_cnt_q & mask) == mask);
    assign is_ext  = src.use_ext;

    always_ff @(posedge clk) begin
        if (restart) begin
            div_cnt_q <= '0;
            tick_q    <= 1'b0;
        end else begin
            if (pre_en) begin
                div_cnt_q <= div_cnt_q + 1'b1;
            end
            tick_q <= src.use_ext ? ext_rise : div_hit;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/tmr_tick_tree.sv
module tmr_tick_tree
    import tmr_tick_pkg::*;
#(
    parameter int unsigned NUM_TMR   = TMR_COUNT,
    parameter int unsigned GRP0_SIZE = GRP0_TMRS,
    parameter int unsigned PRE_W     = PRE_WIDTH,
    parameter int unsigned DATA_W    = BUS_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              variant_b,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              cfg_rd_sel,
    output logic [DATA_W-1:0] cfg_rd_data,
    input  logic [1:0]        ext_clk_in,
    output logic [NUM_TMR-1:0] tick_o
);
    localparam int unsigned NUM_GRP = GRP_COUNT;

    logic [NUM_GRP-1:0][PRE_W-1:0]      pre_val;
    logic [NUM_TMR-1:0][CODE_WIDTH-1:0] sel_code;
    logic                               restart;
    logic [NUM_GRP-1:0]                 pre_en;
    logic [NUM_GRP-1:0]                 ext_rise;
    logic [NUM_TMR-1:0]                 chan_ext;
    dec_variant_e                       var_sel;

    assign var_sel = dec_variant_e'(variant_b);

    tmr_cfg_regs #(
        .DATA_W  (DATA_W),
        .NUM_GRP (NUM_GRP),
        .NUM_TMR (NUM_TMR),
        .PRE_W   (PRE_W)
    ) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .rd_sel   (cfg_rd_sel),
        .rd_data  (cfg_rd_data),
        .pre_val  (pre_val),
        .sel_code (sel_code),
        .restart  (restart)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tmr_prescaler #(.PRE_W(PRE_W)) pre_i (
            .clk     (clk),
            .restart (restart),
            .pre_val (pre_val[g]),
            .pre_en  (pre_en[g])
        );
        tmr_ext_sync sync_i (
            .clk    (clk),
            .rst    (rst),
            .ext_in (ext_clk_in[g]),
            .rise   (ext_rise[g])
        );
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam int unsigned GRP = group_of(t, GRP0_SIZE);
        tmr_chan_div chan_i (
            .clk      (clk),
            .restart  (restart),
            .var_sel  (var_sel),
            .code     (sel_code[t]),
            .pre_en   (pre_en[GRP]),
            .ext_rise (ext_rise[GRP]),
            .tick     (tick_o[t]),
            .is_ext   (chan_ext[t])
        );
    end

endmodule

// File: rtl/tmr_tick_chk.sv
module tmr_tick_chk
    import tmr_tick_pkg::*;
#(
    parameter int unsigned NUM_TMR   = TMR_COUNT,
    parameter int unsigned GRP0_SIZE = GRP0_TMRS,
    parameter int unsigned PRE_W     = PRE_WIDTH,
    parameter int unsigned DATA_W    = BUS_WIDTH
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_wr_en,
    input logic                          cfg_wr_sel,
    input logic [DATA_W-1:0]             cfg_wr_data,
    input logic                          cfg_rd_sel,
    input logic [DATA_W-1:0]             cfg_rd_data,
    input logic [NUM_TMR-1:0]            tick_o,
    input logic [GRP_COUNT-1:0]          pre_en,
    input logic [GRP_COUNT-1:0][PRE_W-1:0] pre_val,
    input logic [GRP_COUNT-1:0]          ext_rise,
    input logic [NUM_TMR-1:0]            chan_ext
);
    localparam int unsigned W0 = GRP_COUNT * PRE_W;
    localparam int unsigned W1 = NUM_TMR * CODE_WIDTH;
    localparam logic [DATA_W-1:0] MASK0 = {{(DATA_W-W0){1'b0}}, {W0{1'b1}}};
    localparam logic [DATA_W-1:0] MASK1 = {{(DATA_W-W1){1'b0}}, {W1{1'b1}}};

    logic started = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!started)
        $past(rst) |-> (tick_o == '0));

    p_readback_w0_r2: assert property (@(posedge clk) disable iff (rst || !started)
        (cfg_wr_en && !cfg_wr_sel) |=> (cfg_rd_sel || (cfg_rd_data == ($past(cfg_wr_data) & MASK0))));

    p_readback_w1_r2: assert property (@(posedge clk) disable iff (rst || !started)
        (cfg_wr_en && cfg_wr_sel) |=> (!cfg_rd_sel || (cfg_rd_data == ($past(cfg_wr_data) & MASK1))));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst || !started)
        (cfg_rd_data & ~(cfg_rd_sel ? MASK1 : MASK0)) == '0);

    p_wr_clear_r8: assert property (@(posedge clk) disable iff (rst || !started)
        cfg_wr_en |=> (tick_o == '0));

    for (genvar g = 0; g < GRP_COUNT; g++) begin : g_grp_chk
        p_pre_gap_r3: assert property (@(posedge clk) disable iff (rst || !started)
            (pre_en[g] && (pre_val[g] != '0) && !cfg_wr_en) |=> !pre_en[g]);
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr_chk
        localparam int unsigned GRP = group_of(t, GRP0_SIZE);
        p_ext_src_r9: assert property (@(posedge clk) disable iff (rst || !started)
            ($past(chan_ext[t]) && tick_o[t]) |-> $past(ext_rise[GRP]));
    end

endmodule

bind tmr_tick_tree tmr_tick_chk #(
    .NUM_TMR   (NUM_TMR),
    .GRP0_SIZE (GRP0_SIZE),
    .PRE_W     (PRE_W),
    .DATA_W    (DATA_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_sel  (cfg_rd_sel),
    .cfg_rd_data (cfg_rd_data),
    .tick_o      (tick_o),
    .pre_en      (pre_en),
    .pre_val     (pre_val),
    .ext_rise    (ext_rise),
    .chan_ext    (chan_ext)
);

// File: tb/tmr_tick_tree_tb_top.sv
module tmr_tick_tree_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        variant_b = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_rd_sel = 1'b0;
    logic [31:0] cfg_rd_data;
    logic [1:0]  ext_clk_in = 2'b00;
    logic [4:0]  tick_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int          cur_p0, cur_p1;
    logic [19:0] cur_w1;

    always #2 clk = ~clk;

    tmr_tick_tree dut_i (
        .clk         (clk),
        .rst         (rst),
        .variant_b   (variant_b),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_sel  (cfg_rd_sel),
        .cfg_rd_data (cfg_rd_data),
        .ext_clk_in  (ext_clk_in),
        .tick_o      (tick_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int code_log2(input logic [3:0] c, input logic vb);
        if (!vb) begin
            if (c < 4) return int'(c) + 1;
            if (c == 4) return -1;
            return 4;
        end
        if (c <= 4) return int'(c);
        return -1;
    endfunction

    function automatic logic [4:0] exp_ticks(input int t, input int p0, input int p1,
                                             input logic [19:0] w1, input logic vb);
        logic [4:0] v = '0;
        for (int i = 0; i < 5; i++) begin
            int l = code_log2(w1[4*i +: 4], vb);
            int p = (i < 2) ? p0 : p1;
            if (l >= 0 && t > 0) v[i] = ((t % ((1 << l) * (p + 1))) == 0);
        end
        return v;
    endfunction

    task automatic do_reset(input logic vb);
        @(negedge clk);
        rst = 1'b1;
        variant_b = vb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_p0 = 0; cur_p1 = 0; cur_w1 = '0;
    endtask

    // Write; returns in cycle 0 after the capturing edge.
    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (!sel) begin cur_p0 = int'(d[7:0]); cur_p1 = int'(d[15:8]); end
        else cur_w1 = d[19:0];
    endtask

    task automatic rd_check(input logic sel, input logic [31:0] exp, input string tag);
        cfg_rd_sel = sel;
        #1;
        check(cfg_rd_data == exp, tag, cfg_rd_data, exp);
    endtask

    // Called right after the final write (cycle 0); checks cycles 0..len.
    task automatic window(input int len, input string tag);
        logic [4:0] e;
        e = exp_ticks(0, cur_p0, cur_p1, cur_w1, variant_b);
        check(tick_o == e, {tag, " R8 cycle0"}, 32'(tick_o), 32'(e));
        for (int t = 1; t <= len; t++) begin
            @(negedge clk);
            e = exp_ticks(t, cur_p0, cur_p1, cur_w1, variant_b);
            check(tick_o == e, tag, 32'(tick_o), 32'(e));
        end
    endtask

    task automatic ext_pulse(input int idx, input logic [4:0] exp, input string tag);
        @(negedge clk);
        ext_clk_in[idx] = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check(tick_o == ((k == 3) ? exp : 5'b0), tag, 32'(tick_o), 32'((k == 3) ? exp : 5'b0));
        end
        ext_clk_in[idx] = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check(tick_o == 5'b0, {tag, " falling"}, 32'(tick_o), 32'h0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));

        // R1: reset state
        @(negedge clk);
        check(tick_o == 5'b0, "R1 tick during reset", 32'(tick_o), 32'h0);
        do_reset(1'b0);
        check(tick_o == 5'b0, "R1 tick after reset", 32'(tick_o), 32'h0);
        rd_check(1'b0, 32'h0, "R1 word0 reset");
        rd_check(1'b1, 32'h0, "R1 word1 reset");

        // R2: reserved bits read as zero
        wr(1'b0, 32'hFFFF_FFFF);
        rd_check(1'b0, 32'h0000_FFFF, "R2 word0 reserved");
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check(1'b1, 32'h000F_FFFF, "R2 word1 reserved");

        // R5 directed: all codes 15 in variant A, P=1 -> period 32
        wr(1'b1, 32'h000F_FFFF);
        wr(1'b0, 32'h0000_0101);
        window(70, "R5 R3 R7 code15");

        // Random configurations in both variants
        for (int vb = 0; vb < 2; vb++) begin
            do_reset(vb[0]);
            for (int n = 0; n < 12; n++) begin
                logic [31:0] d1, d0;
                d1 = $urandom();
                d0 = $urandom();
                d0[7:0]  = 8'($urandom_range(0, 5));
                d0[15:8] = 8'($urandom_range(0, 5));
                wr(1'b1, d1);
                rd_check(1'b1, d1 & 32'h000F_FFFF, "R2 word1 readback");
                wr(1'b0, d0);
                rd_check(1'b0, d0 & 32'h0000_FFFF, "R2 word0 readback");
                window(200, vb == 0 ? "R3 R4 R5 R7 R8 variantA" : "R3 R6 R7 R8 variantB");
            end
        end

        // R6/R7 corner: slowest divide next to a divide-by-1 timer, variant B
        do_reset(1'b1);
        wr(1'b1, 32'h0004_20F0);
        wr(1'b0, 32'h0000_FF00);
        window(8200, "R6 R7 slow corner");

        // R9: external sources, variant A
        do_reset(1'b0);
        wr(1'b1, 32'h0000_4444);
        wr(1'b0, 32'h0000_FFFF);
        ext_pulse(0, 5'b00011, "R9 R4 ext0 group");
        ext_pulse(1, 5'b01100, "R9 R4 ext1 group");

        // R9 with variant B code 9 -> external
        do_reset(1'b1);
        wr(1'b1, 32'h0009_9999);
        wr(1'b0, 32'h0000_FFFF);
        ext_pulse(1, 5'b11100, "R9 R6 ext1 variantB");
        ext_pulse(0, 5'b00011, "R9 R6 ext0 variantB");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule